// File: doc/BRIEF.md
# Secure Memory Region Partition Checker

This block guards one memory slave against accesses from several bus masters. Every request arrives with a physical address, a read/write flag, a non-secure attribute and a privileged attribute. The block looks up the region that covers the address. It then tests the permission bit for the request's security/privilege class and direction. A permitted request goes on to the slave unchanged. A refused request never reaches the slave and completes at once with a bus error.

Regions work on physical 4 KB pages and know nothing of any MMU mapping. Region 0 is a background region that always covers the whole address space. Regions 1 to 8 are programmed with an enable, an inclusive base page, an inclusive top page and eight permission bits. When regions overlap, the highest-numbered region that matches decides.

A small configuration port programs the regions. This port answers only secure accesses. A lock bit freezes the region setup until reset. The first refused access is recorded in a fault record, which also raises an interrupt until a secure write clears it.

Top module: `secure_partition_checker`

## Requirements
- R1: A region matches a request when it is enabled and the request page (address bits 31:12) satisfies base <= page <= top. Both bounds are inclusive and counted in 4 KB pages.
- R2: Region 0 matches every address. Among matching regions, the one with the highest index supplies the permissions. Disabling a region removes it from matching.
- R3: The permission byte is indexed by {write, nonsec, priv}. Bits 3:0 are read permission and bits 7:4 are write permission. Within each nibble the class order is secure-user, secure-privileged, normal-user, normal-privileged.
- R4: A permitted request drives s_valid equal to m_valid and m_ready equal to s_ready, with m_err low. Address and attributes pass through to the slave.
- R5: A refused request keeps s_valid low and returns m_ready and m_err high in the same cycle.
- R6: After reset, region 0 has permission 0x33, meaning secure read and write only. Regions 1 to 8 are disabled and zero. The lock bit and the fault flag are clear, and irq is low.
- R7: A secure write of 1 to word 20 (bit 0) sets the lock. Once the lock is set, writes to region words and to the lock word have no effect until reset.
- R8: A configuration access with cfg_nonsec high returns cfg_err high and cfg_rdata zero, and a write made this way changes nothing.
- R9: The first refused request while the fault flag is clear records its address in word 18 and sets word 19 to {flag at bit 31, write at bit 2, nonsec at bit 1, priv at bit 0}. irq follows the flag. Later refusals do not overwrite the record.
- R10: Any secure write to word 19 clears the fault flag and irq, whether or not the lock is set.
- R11: Region i uses two words. Word 2i holds enable at bit 31 and the base page at bits 19:0. Word 2i+1 holds the permission byte at bits 31:24 and the top page at bits 19:0. For region 0, only the permission byte can be written; it reads back as enabled, base 0, top 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Master request valid |
| m_ready | output | 1 | Request completes this cycle |
| m_addr | input | 32 | Physical address |
| m_write | input | 1 | 1 = write, 0 = read |
| m_nonsec | input | 1 | Non-secure attribute |
| m_priv | input | 1 | Privileged attribute |
| m_err | output | 1 | Bus error response for a refused request |
| s_valid | output | 1 | Request forwarded to slave |
| s_ready | input | 1 | Slave accepts request |
| s_addr | output | 32 | Forwarded address |
| s_write | output | 1 | Forwarded direction |
| s_nonsec | output | 1 | Forwarded non-secure attribute |
| s_priv | output | 1 | Forwarded privileged attribute |
| cfg_valid | input | 1 | Configuration access valid |
| cfg_write | input | 1 | Configuration write |
| cfg_nonsec | input | 1 | Configuration access is non-secure |
| cfg_addr | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, same cycle |
| cfg_err | output | 1 | Configuration access refused |
| irq | output | 1 | Fault flag pending |

## Verification
The permit-or-refuse decision, the slave-side valid, m_ready, m_err, cfg_rdata and cfg_err are all combinational. The bench drives each request on a falling edge and samples these outputs two nanoseconds later, in the same cycle. Configuration writes, the lock and fault capture commit on the next rising edge. The bench therefore checks irq, the fault record and readbacks only after that edge. Each access or write is held for exactly one cycle, so no two stimuli overlap in the state they update.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        CLS_SEC_USR  = 2'd0,
        CLS_SEC_PRIV = 2'd1,
        CLS_NS_USR   = 2'd2,
        CLS_NS_PRIV  = 2'd3
    } acc_class_e;

    localparam logic [7:0] BG_PERM_RST = 8'h33;

    function automatic acc_class_e class_of(input logic nonsec, input logic priv);
        return acc_class_e'({nonsec, priv});
    endfunction

    function automatic logic perm_allows(input logic [7:0] perm, input acc_class_e cls,
                                         input logic wr);
        return perm[{wr, 2'(cls)}];
    endfunction

endpackage

// File: rtl/spc_region_match.sv
module spc_region_match #(
    parameter int NREG = 9,
    parameter int PW   = 20
) (
    input  logic [NREG-1:0]         en,
    input  logic [NREG-1:0][PW-1:0] base,
    input  logic [NREG-1:0][PW-1:0] top,
    input  logic [NREG-1:0][7:0]    perm,
    input  logic [PW-1:0]           page,
    output logic [7:0]              win_perm
);
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit[g] = en[g] && (page >= base[g]) && (page <= top[g]);
    end

    always_comb begin
        win_perm = perm[0];
        for (int i = 1; i < NREG; i++) begin
            if (hit[i]) win_perm = perm[i];
        end
    end
endmodule

// File: rtl/spc_cfg_regs.sv
module spc_cfg_regs #(
    parameter  int NREG = 9,
    parameter  int PW   = 20,
    parameter  int AW   = 32,
    parameter  int DW   = 32,
    localparam int CAW  = $clog2(2*NREG + 3)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_valid,
    input  logic                    cfg_write,
    input  logic                    cfg_nonsec,
    input  logic [CAW-1:0]          cfg_addr,
    input  logic [DW-1:0]           cfg_wdata,
    output logic [DW-1:0]           cfg_rdata,
    output logic                    cfg_err,
    input  logic                    deny,
    input  logic [AW-1:0]           deny_addr,
    input  logic                    deny_write,
    input  logic                    deny_nonsec,
    input  logic                    deny_priv,
    output logic [NREG-1:0]         reg_en,
    output logic [NREG-1:0][PW-1:0] reg_base,
    output logic [NREG-1:0][PW-1:0] reg_top,
    output logic [NREG-1:0][7:0]    reg_perm,
    output logic                    lock,
    output logic                    fault,
    output logic [AW-1:0]           fault_addr
);
    import spc_pkg::*;

    localparam logic [CAW-1:0] IDX_FADDR = CAW'(2*NREG);
    localparam logic [CAW-1:0] IDX_FINFO = CAW'(2*NREG + 1);
    localparam logic [CAW-1:0] IDX_LOCK  = CAW'(2*NREG + 2);

    typedef struct packed {
        logic [NREG-1:0]         en;
        logic [NREG-1:0][PW-1:0] base;
        logic [NREG-1:0][PW-1:0] top;
        logic [NREG-1:0][7:0]    perm;
        logic                    lock;
        logic                    flt;
        logic [AW-1:0]           faddr;
        logic                    fwr;
        logic                    fns;
        logic                    fpriv;
    } state_t;

    state_t s_d, s_q;
    logic   sec_wr, sec_rd;
    logic   wdata_unused;

    assign wdata_unused = ^cfg_wdata[23:PW];
    assign sec_wr = cfg_valid && cfg_write && !cfg_nonsec;
    assign sec_rd = cfg_valid && !cfg_nonsec;

    always_comb begin
        s_d = s_q;
        if (sec_wr && !s_q.lock) begin
            for (int i = 0; i < NREG; i++) begin
                if (cfg_addr == CAW'(2*i)) begin
                    s_d.en[i]   = cfg_wdata[31];
                    s_d.base[i] = cfg_wdata[PW-1:0];
                end
                if (cfg_addr == CAW'(2*i + 1)) begin
                    s_d.perm[i] = cfg_wdata[31:24];
                    s_d.top[i]  = cfg_wdata[PW-1:0];
                end
            end
            if (cfg_addr == IDX_LOCK) s_d.lock = cfg_wdata[0];
        end
        s_d.en[0]   = 1'b1;
        s_d.base[0] = '0;
        s_d.top[0]  = '1;
        if (sec_wr && cfg_addr == IDX_FINFO) s_d.flt = 1'b0;
        if (deny && !s_q.flt) begin
            s_d.flt   = 1'b1;
            s_d.faddr = deny_addr;
            s_d.fwr   = deny_write;
            s_d.fns   = deny_nonsec;
            s_d.fpriv = deny_priv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.en[0]   <= 1'b1;
            s_q.top[0]  <= '1;
            s_q.perm[0] <= BG_PERM_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (sec_rd) begin
            for (int i = 0; i < NREG; i++) begin
                if (cfg_addr == CAW'(2*i)) begin
                    cfg_rdata[31]     = s_q.en[i];
                    cfg_rdata[PW-1:0] = s_q.base[i];
                end
                if (cfg_addr == CAW'(2*i + 1)) begin
                    cfg_rdata[31:24]  = s_q.perm[i];
                    cfg_rdata[PW-1:0] = s_q.top[i];
                end
            end
            if (cfg_addr == IDX_FADDR) cfg_rdata = DW'(s_q.faddr);
            if (cfg_addr == IDX_FINFO) begin
                cfg_rdata[31] = s_q.flt;
                cfg_rdata[2]  = s_q.fwr;
                cfg_rdata[1]  = s_q.fns;
                cfg_rdata[0]  = s_q.fpriv;
            end
            if (cfg_addr == IDX_LOCK) cfg_rdata[0] = s_q.lock;
        end
    end

    assign cfg_err    = cfg_valid && cfg_nonsec;
    assign reg_en     = s_q.en;
    assign reg_base   = s_q.base;
    assign reg_top    = s_q.top;
    assign reg_perm   = s_q.perm;
    assign lock       = s_q.lock;
    assign fault      = s_q.flt;
    assign fault_addr = s_q.faddr;
endmodule

// File: rtl/secure_partition_checker.sv
module secure_partition_checker #(
    parameter  int NREG      = 9,
    parameter  int AW        = 32,
    parameter  int PAGE_BITS = 12,
    parameter  int DW        = 32,
    localparam int PW        = AW - PAGE_BITS,
    localparam int CAW       = $clog2(2*NREG + 3)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           m_valid,
    output logic           m_ready,
    input  logic [AW-1:0]  m_addr,
    input  logic           m_write,
    input  logic           m_nonsec,
    input  logic           m_priv,
    output logic           m_err,
    output logic           s_valid,
    input  logic           s_ready,
    output logic [AW-1:0]  s_addr,
    output logic           s_write,
    output logic           s_nonsec,
    output logic           s_priv,
    input  logic           cfg_valid,
    input  logic           cfg_write,
    input  logic           cfg_nonsec,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic           cfg_err,
    output logic           irq
);
    import spc_pkg::*;

    logic [NREG-1:0]         reg_en;
    logic [NREG-1:0][PW-1:0] reg_base;
    logic [NREG-1:0][PW-1:0] reg_top;
    logic [NREG-1:0][7:0]    reg_perm;
    logic [7:0]              win_perm;
    logic                    allowed;
    logic                    deny;
    logic                    lock;
    logic                    fault;
    logic [AW-1:0]           fault_addr;

    spc_region_match #(.NREG(NREG), .PW(PW)) u_match (
        .en       (reg_en),
        .base     (reg_base),
        .top      (reg_top),
        .perm     (reg_perm),
        .page     (m_addr[AW-1:PAGE_BITS]),
        .win_perm (win_perm)
    );

    assign allowed = perm_allows(win_perm, class_of(m_nonsec, m_priv), m_write);
    assign deny    = m_valid && !allowed;

    assign s_valid  = m_valid && allowed;
    assign m_ready  = allowed ? s_ready : 1'b1;
    assign m_err    = deny;
    assign s_addr   = m_addr;
    assign s_write  = m_write;
    assign s_nonsec = m_nonsec;
    assign s_priv   = m_priv;

    spc_cfg_regs #(.NREG(NREG), .PW(PW), .AW(AW), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid   (cfg_valid),
        .cfg_write   (cfg_write),
        .cfg_nonsec  (cfg_nonsec),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .cfg_err     (cfg_err),
        .deny        (deny),
        .deny_addr   (m_addr),
        .deny_write  (m_write),
        .deny_nonsec (m_nonsec),
        .deny_priv   (m_priv),
        .reg_en      (reg_en),
        .reg_base    (reg_base),
        .reg_top     (reg_top),
        .reg_perm    (reg_perm),
        .lock        (lock),
        .fault       (fault),
        .fault_addr  (fault_addr)
    );

    assign irq = fault;
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int NREG = 9,
    parameter int PW   = 20,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int CAW  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    m_valid,
    input logic                    m_ready,
    input logic                    m_err,
    input logic                    s_valid,
    input logic                    s_ready,
    input logic                    cfg_valid,
    input logic                    cfg_write,
    input logic                    cfg_nonsec,
    input logic [CAW-1:0]          cfg_addr,
    input logic [DW-1:0]           cfg_rdata,
    input logic                    irq,
    input logic                    lock,
    input logic [AW-1:0]           fault_addr,
    input logic [NREG-1:0]         reg_en,
    input logic [NREG-1:0][PW-1:0] reg_base,
    input logic [NREG-1:0][PW-1:0] reg_top,
    input logic [NREG-1:0][7:0]    reg_perm
);
    logic clr;
    assign clr = cfg_valid && cfg_write && !cfg_nonsec && (cfg_addr == CAW'(2*NREG + 1));

    a_r4_fwd_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> m_valid && !m_err);
    a_r4_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && s_ready |-> m_ready);
    a_r5_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> m_ready && !s_valid && m_valid);
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
    a_r7_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(reg_perm) && $stable(reg_base) && $stable(reg_top) && $stable(reg_en));
    a_r8_ns_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_nonsec |-> cfg_rdata == '0);
    a_r8_ns_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_nonsec |=> $stable(reg_perm) && $stable(reg_en) && $stable(lock));
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(m_err));
    a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr |=> irq && $stable(fault_addr));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        irq && clr |=> !irq || $past(m_err));
endmodule

bind secure_partition_checker spc_checker #(
    .NREG(NREG), .PW(PW), .AW(AW), .DW(DW), .CAW(CAW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_err      (m_err),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .cfg_valid  (cfg_valid),
    .cfg_write  (cfg_write),
    .cfg_nonsec (cfg_nonsec),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .irq        (irq),
    .lock       (lock),
    .fault_addr (fault_addr),
    .reg_en     (reg_en),
    .reg_base   (reg_base),
    .reg_top    (reg_top),
    .reg_perm   (reg_perm)
);

// File: tb/sim_secure_partition_checker.sv
module sim_secure_partition_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_valid = 1'b0, m_write = 1'b0, m_nonsec = 1'b0, m_priv = 1'b0;
    logic [31:0] m_addr = '0;
    logic        s_ready = 1'b0;
    logic        m_ready, m_err, s_valid, s_write, s_nonsec, s_priv;
    logic [31:0] s_addr;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0, cfg_nonsec = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [8:0]  men;
    logic [19:0] mbase [9];
    logic [19:0] mtop  [9];
    logic [7:0]  mperm [9];
    bit          mlock, mflt;
    logic [31:0] mfaddr;
    logic [2:0]  mfinfo;

    always #4 clk = ~clk;

    secure_partition_checker u0 (
        .clk(clk), .rst_n(rst_n),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_write(m_write),
        .m_nonsec(m_nonsec), .m_priv(m_priv), .m_err(m_err),
        .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_write(s_write),
        .s_nonsec(s_nonsec), .s_priv(s_priv),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_nonsec(cfg_nonsec),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_err(cfg_err), .irq(irq)
    );

    function automatic logic [7:0] ref_perm(input logic [19:0] page);
        logic [7:0] r = mperm[0];
        for (int i = 1; i < 9; i++)
            if (men[i] && page >= mbase[i] && page <= mtop[i]) r = mperm[i];
        return r;
    endfunction

    function automatic logic ref_allow(input logic [31:0] a, input logic w, input logic ns,
                                       input logic pv);
        logic [7:0] p = ref_perm(a[31:12]);
        return p[{w, ns, pv}];
    endfunction

    function automatic logic [31:0] ref_word(input int idx);
        int r = idx / 2;
        if (idx == 18) return mfaddr;
        if (idx == 19) return {mflt, 28'd0, mfinfo};
        if (idx == 20) return {31'd0, mlock};
        if (idx % 2 == 0) return {men[r], 11'd0, mbase[r]};
        return {mperm[r], 4'd0, mtop[r]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        men = 9'b1;
        for (int i = 0; i < 9; i++) begin
            mbase[i] = '0; mtop[i] = '0; mperm[i] = '0;
        end
        mtop[0] = 20'hFFFFF; mperm[0] = 8'h33;
        mlock = 0; mflt = 0; mfaddr = '0; mfinfo = '0;
    endtask

    task automatic cfg_wr(input int idx, input logic [31:0] d, input logic ns);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_nonsec = ns; cfg_addr = 5'(idx); cfg_wdata = d;
        #2 chk("R8 cfg_err", {31'd0, cfg_err}, {31'd0, ns});
        @(posedge clk);
        #1 cfg_valid = 0; cfg_write = 0; cfg_nonsec = 0;
        if (!ns) begin
            if (idx == 19) mflt = 0;
            if (!mlock) begin
                if (idx < 18) begin
                    if (idx % 2 == 0 && idx != 0) begin men[idx/2] = d[31]; mbase[idx/2] = d[19:0]; end
                    if (idx % 2 == 1) begin
                        mperm[idx/2] = d[31:24];
                        if (idx != 1) mtop[idx/2] = d[19:0];
                    end
                end
                if (idx == 20) mlock = d[0];
            end
        end
    endtask

    task automatic cfg_rd_chk(input string req, input int idx);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 0; cfg_nonsec = 0; cfg_addr = 5'(idx);
        #2 chk(req, cfg_rdata, ref_word(idx));
        @(posedge clk);
        #1 cfg_valid = 0;
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic w,
                          input logic ns, input logic pv, input logic rdy);
        logic ok;
        @(negedge clk);
        m_valid = 1; m_addr = a; m_write = w; m_nonsec = ns; m_priv = pv; s_ready = rdy;
        ok = ref_allow(a, w, ns, pv);
        #2;
        chk({req, " R4/R5 s_valid"}, {31'd0, s_valid}, {31'd0, ok});
        chk({req, " R4/R5 m_ready"}, {31'd0, m_ready}, {31'd0, ok ? rdy : 1'b1});
        chk({req, " R5 m_err"}, {31'd0, m_err}, {31'd0, !ok});
        if (ok) chk("R4 s_addr", s_addr, a);
        @(posedge clk);
        if (!ok && !mflt) begin mflt = 1; mfaddr = a; mfinfo = {w, ns, pv}; end
        #1 m_valid = 0;
        chk("R9 irq", {31'd0, irq}, {31'd0, mflt});
    endtask

    task automatic all_classes(input string req, input logic [31:0] a);
        for (int c = 0; c < 8; c++) access(req, a, c[2], c[1], c[0], c[0] ^ c[1]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R4 act=hung exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0013));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R6 reset state, R11 region 0 layout
        chk("R6 irq", {31'd0, irq}, 32'd0);
        cfg_rd_chk("R6 R11 region0 word A", 0);
        cfg_rd_chk("R6 R11 region0 word B", 1);
        cfg_rd_chk("R6 region3 word B", 7);
        cfg_rd_chk("R6 lock", 20);
        cfg_rd_chk("R6 fault info", 19);

        // R3 background: secure only
        all_classes("R2 R3 background", 32'h1234_5000);
        cfg_rd_chk("R9 fault addr", 18);
        cfg_rd_chk("R9 fault info", 19);
        access("R9 second deny", 32'h0000_7000, 1, 1, 1, 0);
        cfg_rd_chk("R9 record kept", 18);
        // R8 non-secure clear attempt is ignored
        cfg_wr(19, 32'h0, 1);
        cfg_rd_chk("R8 flag kept", 19);
        @(negedge clk);
        cfg_valid = 1; cfg_nonsec = 1; cfg_addr = 5'd1;
        #2 chk("R8 ns read zero", cfg_rdata, 32'h0);
        @(posedge clk); #1 cfg_valid = 0; cfg_nonsec = 0;
        // R10 secure clear
        cfg_wr(19, 32'h0, 0);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);
        cfg_rd_chk("R10 info cleared", 19);

        // R1 shared / normal-only / secure-only layout
        cfg_wr(2, {1'b1, 11'd0, 20'd0}, 0);
        cfg_wr(3, {8'hFF, 4'd0, 20'd2559}, 0);
        cfg_wr(4, {1'b1, 11'd0, 20'd2560}, 0);
        cfg_wr(5, {8'hCC, 4'd0, 20'd16383}, 0);
        cfg_wr(6, {1'b1, 11'd0, 20'd16384}, 0);
        cfg_wr(7, {8'h33, 4'd0, 20'd32767}, 0);
        for (int i = 2; i < 8; i++) cfg_rd_chk("R11 layout readback", i);
        all_classes("R1 shared top", 32'h009F_FFFC);
        all_classes("R1 normal base", 32'h00A0_0000);
        all_classes("R1 normal top", 32'h03FF_FFFC);
        all_classes("R1 secure base", 32'h0400_0000);
        all_classes("R1 secure top", 32'h07FF_F000);
        all_classes("R1 past top", 32'h0800_0000);
        // R8 non-secure write is ignored
        cfg_wr(3, 32'h0, 1);
        cfg_rd_chk("R8 region kept", 3);
        all_classes("R8 perm unchanged", 32'h0000_1000);

        // R2 priority on overlap
        cfg_wr(8, {1'b1, 11'd0, 20'd150}, 0);
        cfg_wr(9, {8'hFF, 4'd0, 20'd300}, 0);
        cfg_wr(10, {1'b1, 11'd0, 20'd100}, 0);
        cfg_wr(11, {8'h00, 4'd0, 20'd200}, 0);
        all_classes("R2 overlap high wins", 32'h000A_0000);
        all_classes("R2 upper only", 32'h000F_A000);
        cfg_wr(10, {1'b0, 11'd0, 20'd100}, 0);
        all_classes("R2 disabled", 32'h000A_0000);
        cfg_wr(19, 32'h0, 0);

        // random regions and accesses
        for (int r = 0; r < 25; r++) begin
            int reg_i = 1 + ($urandom % 8);
            logic [19:0] b = 20'($urandom % 64);
            cfg_wr(2*reg_i, {1'($urandom), 11'd0, b}, ($urandom % 10) == 0);
            cfg_wr(2*reg_i + 1, {8'($urandom), 4'd0, b + 20'($urandom % 40)}, ($urandom % 10) == 0);
            for (int k = 0; k < 30; k++)
                access("R1 R2 R3 random", {20'($urandom % 128), 12'($urandom)},
                       1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (r % 5 == 0) begin
                cfg_rd_chk("R9 random fault addr", 18);
                cfg_wr(19, 32'h0, 0);
            end
        end

        // R7 lock
        cfg_wr(20, 32'h1, 0);
        cfg_rd_chk("R7 lock set", 20);
        cfg_wr(3, 32'h0, 0);
        cfg_rd_chk("R7 region frozen", 3);
        cfg_wr(0, {8'h00, 24'd0}, 0);
        cfg_wr(1, {8'hFF, 24'd0}, 0);
        cfg_rd_chk("R7 region0 frozen", 1);
        cfg_wr(20, 32'h0, 0);
        cfg_rd_chk("R7 lock kept", 20);
        all_classes("R7 perms kept", 32'h0000_0000);
        access("R10 deny after lock", 32'h0900_0000, 0, 1, 0, 1);
        cfg_wr(19, 32'h0, 0);
        chk("R10 clear under lock", {31'd0, irq}, 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule